// File: doc/BRIEF.md
# Discontinuous Scan Sequence Controller

This block walks a programmable list of channel numbers (the regular sequence) and hands each one in turn to an external converter. In discontinuous mode the list is cut into subgroups of a programmed size. Each start trigger converts only the next subgroup. The controller keeps its place between triggers, cuts the last subgroup short when the list length is not a multiple of the size, and returns to the first slot after the last subgroup. With discontinuous mode off, one trigger runs the whole list in a single pass.

The converter is reached through a simple handshake. A one-cycle request carries the channel number. The converter later answers with a one-cycle done strobe and a 12-bit sample. Each sample is presented for one cycle on a result strobe, together with the channel it came from and the slot it belongs to, and an end-of-conversion pulse marks every finished channel. Clearing the power bit drops any conversion in flight and puts the position back to the first slot, so that after power returns the results line up with slot order again.

Top module: `subgroup_sequencer`

## Requirements
- R1: After reset `conv_req`, `res_valid` and `eoc` are low, and the first accepted trigger starts at slot 0.
- R2: `cfg_grp_m1` is 3 bits and holds the subgroup size minus one (0 means 1 channel, 7 means 8 channels). With `cfg_disc_en`=1, one trigger converts exactly `cfg_grp_m1`+1 slots, unless the end of the list comes first.
- R3: The position is kept across triggers: each trigger continues with the slot after the last one converted by the previous trigger.
- R4: When the list length is not a multiple of the subgroup size, the final subgroup holds only the remaining slots (7 slots in groups of 2 give 2, 2, 2, 1).
- R5: A trigger that comes after the final subgroup has completed starts again at slot 0.
- R6: `eoc` pulses high for one cycle for every converted channel, in the same cycle as `res_valid`.
- R7: Results leave in slot order. `res_chan` is the channel stored in the slot, `res_slot` is the slot index, and `res_data` is the sample the converter returned for that request. A channel number may sit in several slots.
- R8: While `cfg_power` is 0, no request is issued and triggers have no effect. Clearing `cfg_power` returns the position to slot 0.
- R9: With `cfg_disc_en`=0, one trigger converts from the current position through the last slot of the list.
- R10: A trigger that arrives while a subgroup is still converting is ignored. It is not queued and does not move the position.
- R11: `conv_req` is a one-cycle pulse with `conv_chan` valid. No new request is issued until `conv_done` has answered the previous one.
- R12: `cfg_len_m1` holds the list length minus one (1 to 16 slots). Slots are written through `cfg_wr_en`/`cfg_wr_slot`/`cfg_wr_chan` with 5-bit channel numbers, and `res_slot` never exceeds `cfg_len_m1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_power | input | 1 | Enable/power bit; 0 aborts and rewinds to slot 0 |
| cfg_disc_en | input | 1 | 1 selects subgroup-per-trigger operation |
| cfg_grp_m1 | input | 3 | Subgroup size minus one |
| cfg_len_m1 | input | 4 | List length minus one |
| cfg_wr_en | input | 1 | Slot write strobe |
| cfg_wr_slot | input | 4 | Slot index to write |
| cfg_wr_chan | input | 5 | Channel number written into the slot |
| start | input | 1 | Start trigger, one cycle |
| conv_req | output | 1 | Conversion request pulse |
| conv_chan | output | 5 | Channel to convert, valid with conv_req |
| conv_done | input | 1 | Converter finished, one cycle |
| conv_data | input | 12 | Converter sample, valid with conv_done |
| res_valid | output | 1 | Result strobe |
| res_data | output | 12 | Result sample |
| res_chan | output | 5 | Channel of the result |
| res_slot | output | 4 | Slot index of the result |
| eoc | output | 1 | End-of-conversion pulse per channel |

## Verification
The bench builds the block with its defaults: 16 slots, 5-bit channels, 12-bit samples and subgroups of up to 8. This puts the full 16-entry list split into two groups of eight, the single-slot list and the one-channel subgroup within reach. The converter model answers after three cycles of latency, so each subgroup keeps the block busy long enough for a second trigger to land mid-burst. Each sample encodes the channel and a running count, so a shifted or repeated slot shows up as a data mismatch.

// File: rtl/subseq_pkg.sv
package subseq_pkg;

  // Control states of the request stepper
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } step_state_e;

endpackage

// File: rtl/subseq_slot_table.sv
module subseq_slot_table #(
  parameter int NSLOT = 16,
  parameter int CHW   = 5,
  localparam int IW   = $clog2(NSLOT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_slot,
  input  logic [CHW-1:0] wr_chan,
  input  logic [IW-1:0]  rd_slot,
  output logic [CHW-1:0] rd_chan
);

  logic [CHW-1:0] slot_q [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_slot == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (hit) begin
        slot_q[g] <= wr_chan;
      end
    end
  end

  assign rd_chan = slot_q[rd_slot];

endmodule

// File: rtl/subseq_cursor.sv
module subseq_cursor #(
  parameter int NSLOT = 16,
  parameter int GMAX  = 8,
  localparam int IW   = $clog2(NSLOT),
  localparam int GW   = $clog2(GMAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  input  logic          disc_en,
  input  logic [IW-1:0] len_m1,
  input  logic [GW-1:0] grp_m1,
  output logic [IW-1:0] pos,
  output logic          burst_end
);

  logic [IW-1:0] pos_q, pos_d;
  logic [GW-1:0] cnt_q, cnt_d;
  logic          seq_last;
  logic          grp_last;

  // Current slot is the last of the list, or the last of its subgroup
  assign seq_last  = (pos_q >= len_m1);
  assign grp_last  = disc_en && (cnt_q == grp_m1);
  assign burst_end = seq_last || grp_last;

  always_comb begin
    pos_d = pos_q;
    cnt_d = cnt_q;
    if (clear) begin
      pos_d = '0;
      cnt_d = '0;
    end else if (advance) begin
      pos_d = seq_last  ? '0 : pos_q + 1'b1;
      cnt_d = burst_end ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      cnt_q <= '0;
    end else begin
      pos_q <= pos_d;
      cnt_q <= cnt_d;
    end
  end

  assign pos = pos_q;

endmodule

// File: rtl/subseq_step_fsm.sv
module subseq_step_fsm
  import subseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic power,
  input  logic start,
  input  logic done,
  input  logic burst_end,
  output logic req,
  output logic advance
);

  step_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_ISSUE;
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT:  if (done) state_d = burst_end ? ST_IDLE : ST_ISSUE;
      default:  state_d = ST_IDLE;
    endcase
    if (!power) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign req     = (state_q == ST_ISSUE);
  assign advance = (state_q == ST_WAIT) && done && power;

endmodule

// File: rtl/subseq_result.sv
module subseq_result #(
  parameter int DW  = 12,
  parameter int CHW = 5,
  parameter int IW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture,
  input  logic [DW-1:0]  in_data,
  input  logic [CHW-1:0] in_chan,
  input  logic [IW-1:0]  in_slot,
  output logic           out_valid,
  output logic           out_eoc,
  output logic [DW-1:0]  out_data,
  output logic [CHW-1:0] out_chan,
  output logic [IW-1:0]  out_slot
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_eoc   <= 1'b0;
    end else begin
      out_valid <= capture;
      out_eoc   <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_chan <= '0;
      out_slot <= '0;
    end else if (capture) begin
      out_data <= in_data;
      out_chan <= in_chan;
      out_slot <= in_slot;
    end
  end

endmodule

// File: rtl/subgroup_sequencer.sv
module subgroup_sequencer #(
  parameter int NSLOT = 16,
  parameter int CHW   = 5,
  parameter int DW    = 12,
  parameter int GMAX  = 8,
  localparam int IW   = $clog2(NSLOT),
  localparam int GW   = $clog2(GMAX)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_power,
  input  logic           cfg_disc_en,
  input  logic [GW-1:0]  cfg_grp_m1,
  input  logic [IW-1:0]  cfg_len_m1,
  input  logic           cfg_wr_en,
  input  logic [IW-1:0]  cfg_wr_slot,
  input  logic [CHW-1:0] cfg_wr_chan,
  input  logic           start,
  output logic           conv_req,
  output logic [CHW-1:0] conv_chan,
  input  logic           conv_done,
  input  logic [DW-1:0]  conv_data,
  output logic           res_valid,
  output logic [DW-1:0]  res_data,
  output logic [CHW-1:0] res_chan,
  output logic [IW-1:0]  res_slot,
  output logic           eoc
);

  logic [IW-1:0]  cur_pos;
  logic [CHW-1:0] cur_chan;
  logic           burst_end;
  logic           step_adv;

  subseq_slot_table #(.NSLOT(NSLOT), .CHW(CHW)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_slot (cfg_wr_slot),
    .wr_chan (cfg_wr_chan),
    .rd_slot (cur_pos),
    .rd_chan (cur_chan)
  );

  subseq_cursor #(.NSLOT(NSLOT), .GMAX(GMAX)) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!cfg_power),
    .advance   (step_adv),
    .disc_en   (cfg_disc_en),
    .len_m1    (cfg_len_m1),
    .grp_m1    (cfg_grp_m1),
    .pos       (cur_pos),
    .burst_end (burst_end)
  );

  subseq_step_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .power     (cfg_power),
    .start     (start),
    .done      (conv_done),
    .burst_end (burst_end),
    .req       (conv_req),
    .advance   (step_adv)
  );

  subseq_result #(.DW(DW), .CHW(CHW), .IW(IW)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (step_adv),
    .in_data   (conv_data),
    .in_chan   (cur_chan),
    .in_slot   (cur_pos),
    .out_valid (res_valid),
    .out_eoc   (eoc),
    .out_data  (res_data),
    .out_chan  (res_chan),
    .out_slot  (res_slot)
  );

  assign conv_chan = cur_chan;

endmodule

// File: rtl/subseq_checker.sv
module subseq_checker #(
  parameter int NSLOT = 16,
  parameter int GMAX  = 8,
  localparam int IW   = $clog2(NSLOT),
  localparam int GW   = $clog2(GMAX)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_power,
  input logic          cfg_disc_en,
  input logic [GW-1:0] cfg_grp_m1,
  input logic [IW-1:0] cfg_len_m1,
  input logic          start,
  input logic          conv_req,
  input logic          conv_done,
  input logic          res_valid,
  input logic          eoc,
  input logic [IW-1:0] res_slot
);

  logic          outstanding_q;
  logic [IW:0]   seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding_q <= 1'b0;
    end else if (conv_req) begin
      outstanding_q <= 1'b1;
    end else if (conv_done) begin
      outstanding_q <= 1'b0;
    end
  end

  // Results counted since the last trigger or power-down
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (!cfg_power || start) begin
      seen_q <= '0;
    end else if (res_valid && (seen_q != '1)) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> !outstanding_q); // R11

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req); // R11

  AST_RESULT_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(conv_done)); // R7

  AST_EOC_EACH: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && outstanding_q && cfg_power) |=> eoc); // R6

  AST_EOC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc); // R6

  AST_QUIET_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_power |=> !conv_req); // R8

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_slot <= cfg_len_m1)); // R12

  AST_GROUP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cfg_disc_en) |-> (seen_q <= (IW+1)'(cfg_grp_m1))); // R2

endmodule

bind subgroup_sequencer subseq_checker #(.NSLOT(NSLOT), .GMAX(GMAX)) u_chk (.*);

// File: tb/subgroup_sequencer_bench.sv
`timescale 1ns/1ps
module subgroup_sequencer_bench;

  localparam int NSLOT = 16;
  localparam int CHW   = 5;
  localparam int DW    = 12;
  localparam int GMAX  = 8;
  localparam int IW    = $clog2(NSLOT);
  localparam int GW    = $clog2(GMAX);
  localparam int LAT   = 3;

  logic           clk;
  logic           rst_n;
  logic           cfg_power;
  logic           cfg_disc_en;
  logic [GW-1:0]  cfg_grp_m1;
  logic [IW-1:0]  cfg_len_m1;
  logic           cfg_wr_en;
  logic [IW-1:0]  cfg_wr_slot;
  logic [CHW-1:0] cfg_wr_chan;
  logic           start;
  logic           conv_req;
  logic [CHW-1:0] conv_chan;
  logic           conv_done;
  logic [DW-1:0]  conv_data;
  logic           res_valid;
  logic [DW-1:0]  res_data;
  logic [CHW-1:0] res_chan;
  logic [IW-1:0]  res_slot;
  logic           eoc;

  subgroup_sequencer u_subgroup_sequencer (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Converter model: answers each request after LAT idle cycles
  logic [CHW-1:0] m_chan;
  logic [6:0]     m_count;
  logic           m_busy;
  int             m_wait;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_done <= 1'b0;
      conv_data <= '0;
      m_chan    <= '0;
      m_count   <= '0;
      m_busy    <= 1'b0;
      m_wait    <= 0;
    end else begin
      conv_done <= 1'b0;
      if (conv_req) begin
        m_chan <= conv_chan;
        m_busy <= 1'b1;
        m_wait <= LAT;
      end else if (m_busy) begin
        if (m_wait == 0) begin
          conv_done <= 1'b1;
          conv_data <= {m_chan, m_count};
          m_count   <= m_count + 1'b1;
          m_busy    <= 1'b0;
        end else begin
          m_wait <= m_wait - 1;
        end
      end
    end
  end

  // Scoreboard state
  logic [20:0] exp_q[$];
  int          checks;
  int          errors;
  int          req_seen;
  int          exp_n;
  int          b_pos;
  int          b_len;
  int          b_grp;
  bit          b_disc;
  int          seq [NSLOT];
  string       cur_req;
  bit          finished;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Monitor: compares each result against the head of the queue
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (conv_req) req_seen++;
      if (res_valid || eoc)
        check(eoc === res_valid, "R6 eoc with result", int'(eoc), int'(res_valid));
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, {cur_req, " unexpected result slot"}, int'(res_slot), -1);
        end else begin
          logic [20:0] e;
          logic [20:0] a;
          e = exp_q.pop_front();
          a = {res_chan, res_slot, res_data};
          check(a == e, {cur_req, " result {chan,slot,data}"}, int'(a), int'(e));
        end
      end
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  // Model of the expected subgroup, built from the requirements
  task automatic expect_burst();
    int  n;
    bit  last;
    n = 0;
    do begin
      logic [CHW-1:0] ch;
      ch = CHW'(seq[b_pos]);
      exp_q.push_back({ch, IW'(b_pos), ch, 7'(exp_n)});
      exp_n++;
      n++;
      last  = (b_pos == b_len - 1);
      b_pos = last ? 0 : b_pos + 1;
    end while (!(last || (b_disc && n == b_grp)));
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_drain();
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check(exp_q.size() == 0, {cur_req, " results pending"}, exp_q.size(), 0);
    exp_q.delete();
    repeat (12) @(negedge clk);
  endtask

  task automatic trigger(input string tag);
    cur_req = tag;
    expect_burst();
    pulse_start();
    wait_drain();
  endtask

  task automatic write_slot(input int idx, input int ch);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_slot = IW'(idx);
    cfg_wr_chan = CHW'(ch);
    seq[idx]    = ch;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  task automatic set_cfg(input int len, input int grp, input bit disc);
    @(negedge clk);
    cfg_len_m1  = IW'(len - 1);
    cfg_grp_m1  = GW'(grp - 1);
    cfg_disc_en = disc;
    b_len  = len;
    b_grp  = grp;
    b_disc = disc;
  endtask

  task automatic power_cycle();
    @(negedge clk) cfg_power = 1'b0;
    @(negedge clk) cfg_power = 1'b1;
    b_pos = 0;
  endtask

  initial begin
    int r;
    checks = 0; errors = 0; req_seen = 0; exp_n = 0; b_pos = 0;
    finished = 1'b0; cur_req = "R1";
    rst_n = 1'b0; cfg_power = 1'b0; cfg_disc_en = 1'b0; cfg_grp_m1 = '0;
    cfg_len_m1 = '0; cfg_wr_en = 1'b0; cfg_wr_slot = '0; cfg_wr_chan = '0;
    start = 1'b0;
    for (int i = 0; i < NSLOT; i++) seq[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 1'b0, "R1 res_valid after reset", int'(res_valid), 0);
    check(eoc == 1'b0, "R1 eoc after reset", int'(eoc), 0);
    check(conv_req == 1'b0, "R1 conv_req after reset", int'(conv_req), 0);

    // Seven slots, subgroups of two
    write_slot(0, 3);  write_slot(1, 17); write_slot(2, 5);  write_slot(3, 9);
    write_slot(4, 31); write_slot(5, 0);  write_slot(6, 12);
    set_cfg(7, 2, 1'b1);
    @(negedge clk) cfg_power = 1'b1;
    trigger("R1");            // slots 0,1
    trigger("R3");            // slots 2,3
    trigger("R2");            // slots 4,5
    trigger("R4");            // slot 6 alone
    trigger("R5");            // wraps to slots 0,1

    // Trigger while busy: must not queue or move the position
    cur_req = "R10";
    expect_burst();           // slots 2,3
    pulse_start();
    repeat (2) @(negedge clk);
    pulse_start();
    wait_drain();
    r = req_seen;
    trigger("R10");           // slots 4,5 follow directly
    check(req_seen - r == 2, "R10 requests for next subgroup", req_seen - r, 2);

    // Power clear rewinds; triggers while unpowered do nothing
    cur_req = "R8";
    @(negedge clk) cfg_power = 1'b0;
    b_pos = 0;
    r = req_seen;
    pulse_start();
    repeat (20) @(negedge clk);
    check(req_seen == r, "R8 no request while unpowered", req_seen - r, 0);
    @(negedge clk) cfg_power = 1'b1;
    trigger("R8");            // slots 0,1

    // Repeated channels in subgroups of three
    for (int i = 0; i < 6; i++) write_slot(i, i % 2);
    set_cfg(6, 3, 1'b1);
    power_cycle();
    trigger("R7");
    trigger("R7");
    trigger("R5");

    // Whole list per trigger
    set_cfg(6, 3, 1'b0);
    trigger("R9");
    trigger("R9");

    // Sixteen slots in groups of eight
    for (int i = 0; i < NSLOT; i++) write_slot(i, (i * 7 + 3) % 32);
    set_cfg(16, 8, 1'b1);
    power_cycle();
    trigger("R12");
    trigger("R2");
    trigger("R5");

    // Single-slot list
    set_cfg(1, 3, 1'b1);
    power_cycle();
    trigger("R12");
    trigger("R4");

    // One channel per subgroup
    set_cfg(3, 1, 1'b1);
    power_cycle();
    trigger("R2");
    trigger("R3");
    trigger("R3");
    trigger("R5");

    summary();
    $finish;
  end

endmodule